// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the fast reference clock down to a once-per-second tick, and each tick advances the seconds count. The prescaler is set through one register that holds a divider in its low half and a signed trim in its high half. On every `TrimEvery`-th tick, the trim lengthens or shortens that tick period, so a reference clock that is a little fast or slow can be corrected over time. While that register holds zero, the prescaler is stopped and time stands still.

A 32-bit alarm value is compared with the seconds count. One status register holds two sticky event flags and two interrupt enables. One flag marks an alarm match and the other marks each tick. Each interrupt output is its flag gated by its enable. Software clears a flag by writing a one to its bit. Software sets the time by writing the count directly, and that write restarts the prescaler phase.

Access is through a simple single-cycle 32-bit register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `secs_rtc`

## Requirements
- R1: After reset, all four registers read zero and both interrupt outputs are low.
- R2: The byte offsets are alarm 0x00, seconds count 0x04, trim/divider 0x08 and status 0x10. Alarm, count and trim/divider read back what was written. Any other offset reads zero, and a write to it changes no register.
- R3: Status bit 0 is the alarm flag, bit 1 is the tick flag, bit 2 is the alarm interrupt enable and bit 3 is the tick interrupt enable. Bits 3:2 are read/write. All other bits read zero.
- R4: Writing a one to status bit 0 or bit 1 clears that flag. Writing a zero leaves the flag unchanged.
- R5: When the trim field (bits 31:16) is zero and the divider D (bits 15:0) is not zero, a tick occurs every D+1 clock cycles. Each tick adds one to the count and sets the tick flag.
- R6: The trim field is a signed 16-bit value T. Every `TrimEvery`-th tick period lasts max(D+T,0)+1 cycles. All other tick periods last D+1 cycles.
- R7: While the whole trim/divider register is zero, no tick occurs and the count holds its value.
- R8: A write to the count loads the new value and restarts the prescaler phase and the trim sequence. The first tick after the write lands D+1 cycles later.
- R9: The alarm flag sets one cycle after the count becomes equal to the alarm value. This applies whether the match comes from a tick, a count write or an alarm write.
- R10: The alarm interrupt output is high exactly when the alarm flag and its enable are both set. The tick interrupt output is high exactly when the tick flag and its enable are both set.
- R11: When a write-one-to-clear lands on the same edge as a new event for that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; drives both the prescaler and the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | When high, the access is a write |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| irqTick | output | 1 | Tick interrupt |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
On every cycle, the assertions check these properties:
- The count advances by exactly one per tick and holds while the prescaler is stopped.
- A written zero never clears a flag.
- A new alarm event always leaves its flag set.
- Each rise of the alarm flag follows a cycle in which the count equalled the alarm.
- At most one register is written per access.

Some behaviour only the bench scenarios can show, because it needs the timing measured from a write:
- the exact period in cycles for a given divider and trim, including clamping of a negative trim;
- the restarted phase after a count write;
- alarm matches reached by random values;
- the same-edge collision between a clear and a tick.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int AddrW = 5;

  // Byte offsets of the four registers
  localparam logic [AddrW-1:0] OffAlarm = 5'h00;
  localparam logic [AddrW-1:0] OffCount = 5'h04;
  localparam logic [AddrW-1:0] OffTrim  = 5'h08;
  localparam logic [AddrW-1:0] OffStat  = 5'h10;

  // Write strobes from the control to the datapath
  typedef struct packed {
    logic wrAlarm;
    logic wrCount;
    logic wrTrim;
    logic wrStat;
  } regStrobe_t;

  // Status register layout, packed MSB first: bit3..bit0
  typedef struct packed {
    logic tickEn;
    logic alarmEn;
    logic tickFlag;
    logic alarmFlag;
  } statBits_t;
endpackage

// File: rtl/secs_rtc_ctrl.sv
module secs_rtc_ctrl
  import secs_rtc_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] alarmVal,
  input  logic [DataW-1:0] countVal,
  input  logic [DataW-1:0] trimVal,
  input  statBits_t        stat,
  output regStrobe_t       strobe,
  output logic [DataW-1:0] busRdata
);
  logic wrAcc;
  assign wrAcc = busSel && busWr;

  always_comb begin
    strobe         = '0;
    strobe.wrAlarm = wrAcc && (busAddr == OffAlarm);
    strobe.wrCount = wrAcc && (busAddr == OffCount);
    strobe.wrTrim  = wrAcc && (busAddr == OffTrim);
    strobe.wrStat  = wrAcc && (busAddr == OffStat);
  end

  always_comb begin
    unique case (busAddr)
      OffAlarm: busRdata = alarmVal;
      OffCount: busRdata = countVal;
      OffTrim:  busRdata = trimVal;
      OffStat:  busRdata = {{(DataW-4){1'b0}}, stat};
      default:  busRdata = '0;
    endcase
  end

  // R2: a single access never writes two registers
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/secs_rtc_dp.sv
module secs_rtc_dp
  import secs_rtc_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int DivW      = 16,
  parameter int TrimEvery = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [DataW-1:0] wdata,
  output logic [DataW-1:0] alarmVal,
  output logic [DataW-1:0] countVal,
  output logic [DataW-1:0] trimVal,
  output statBits_t        stat,
  output logic             irqTick,
  output logic             irqAlarm
);
  localparam int TrimW = DataW - DivW;
  localparam int LimW  = ((DivW > TrimW) ? DivW : TrimW) + 2;
  localparam int TcW   = (TrimEvery > 1) ? $clog2(TrimEvery) : 1;

  logic [DataW-1:0] alarmReg, countReg, trimReg;
  logic [LimW-2:0]  preCnt, limitU;
  logic [TcW-1:0]   trimCnt;
  logic signed [LimW-1:0] divS, trimS, sumS;
  logic running, trimCycle, tickPulse, tickEvt;
  logic cmpNow, cmpQ, alarmEvt;
  statBits_t statQ;

  assign running   = |trimReg;
  assign trimCycle = (trimCnt == TcW'(TrimEvery - 1));

  always_comb begin
    divS  = $signed({{(LimW-DivW){1'b0}}, trimReg[DivW-1:0]});
    trimS = trimCycle ? $signed({{(LimW-TrimW){trimReg[DataW-1]}}, trimReg[DataW-1:DivW]})
                      : '0;
    sumS  = divS + trimS;
    limitU = sumS[LimW-1] ? '0 : sumS[LimW-2:0];
  end

  assign tickPulse = running && (preCnt >= limitU);
  assign tickEvt   = tickPulse && !strobe.wrCount;
  assign cmpNow    = (countReg == alarmReg);
  assign alarmEvt  = cmpNow && !cmpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmReg <= '0;
      countReg <= '0;
      trimReg  <= '0;
      preCnt   <= '0;
      trimCnt  <= '0;
      cmpQ     <= 1'b1;
      statQ    <= '0;
    end else begin
      if (strobe.wrAlarm) alarmReg <= wdata;
      if (strobe.wrTrim)  trimReg  <= wdata;
      if (strobe.wrCount) begin
        countReg <= wdata;
        preCnt   <= '0;
        trimCnt  <= '0;
      end else if (tickPulse) begin
        countReg <= countReg + 1'b1;
        preCnt   <= '0;
        trimCnt  <= trimCycle ? '0 : trimCnt + 1'b1;
      end else if (running) begin
        preCnt <= preCnt + 1'b1;
      end
      cmpQ <= cmpNow;
      if (strobe.wrStat) begin
        statQ.tickEn  <= wdata[3];
        statQ.alarmEn <= wdata[2];
      end
      statQ.alarmFlag <= alarmEvt | (statQ.alarmFlag & ~(strobe.wrStat & wdata[0]));
      statQ.tickFlag  <= tickEvt  | (statQ.tickFlag  & ~(strobe.wrStat & wdata[1]));
    end
  end

  assign alarmVal = alarmReg;
  assign countVal = countReg;
  assign trimVal  = trimReg;
  assign stat     = statQ;
  assign irqTick  = statQ.tickFlag  & statQ.tickEn;
  assign irqAlarm = statQ.alarmFlag & statQ.alarmEn;

  // R5: each tick moves the count up by exactly one
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickPulse && !strobe.wrCount) |=> (countReg == $past(countReg) + 1'b1));

  // R7: a cleared trim/divider register freezes the count
  p_halt_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trimReg == '0 && !strobe.wrCount) |=> (countReg == $past(countReg)));

  // R4: writing zero to the alarm flag bit keeps it set
  p_w0_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStat && !wdata[0] && statQ.alarmFlag) |=> statQ.alarmFlag);

  // R11: a fresh alarm event survives a same-edge clear
  p_evt_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> statQ.alarmFlag);

  // R9: the alarm flag only rises after a cycle of equality
  p_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ.alarmFlag) |-> $past(countReg == alarmReg));
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int DivW      = 16,
  parameter int TrimEvery = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic             irqTick,
  output logic             irqAlarm
);
  regStrobe_t strobe;
  statBits_t  stat;
  logic [DataW-1:0] alarmVal, countVal, trimVal;

  secs_rtc_ctrl #(.DataW(DataW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .alarmVal(alarmVal), .countVal(countVal), .trimVal(trimVal), .stat(stat),
    .strobe(strobe), .busRdata(busRdata)
  );

  secs_rtc_dp #(.DataW(DataW), .DivW(DivW), .TrimEvery(TrimEvery)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .alarmVal(alarmVal), .countVal(countVal), .trimVal(trimVal), .stat(stat),
    .irqTick(irqTick), .irqAlarm(irqAlarm)
  );
endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;
  localparam int Every = 4;
  localparam logic [4:0] AAl = 5'h00, ACn = 5'h04, ATr = 5'h08, ASt = 5'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqTick, irqAlarm;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  secs_rtc #(.TrimEvery(Every)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqTick(irqTick), .irqAlarm(irqAlarm)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; #1;
    d = busRdata;
  endtask

  task automatic rdAfter(int n, logic [4:0] a, output logic [31:0] d);
    repeat (n) @(posedge clk);
    rd(a, d);
  endtask

  // Cycles from a count write until the n-th tick lands
  function automatic int cyclesFor(int d, int t, int n);
    int c = 0;
    for (int i = 1; i <= n; i++) begin
      int lim = (i % Every == 0) ? d + t : d;
      if (lim < 0) lim = 0;
      c += lim + 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] expCount(logic [31:0] v, int cyc, int d);
    return v + 32'(cyc / (d + 1));
  endfunction

  task automatic trimCase(int d, int t, string tag);
    logic [31:0] r;
    int c;
    c = cyclesFor(d, t, Every);
    wr(ATr, {16'(t), 16'(d)});
    wr(ACn, 32'd0);
    rdAfter(c - 1, ACn, r); check(tag, r, Every - 1);
    rdAfter(1, ACn, r);     check(tag, r, Every);
  endtask

  initial begin
    logic [31:0] r, v;
    int d, k;
    void'($urandom(32'h5eed_1234));
    #23 rstN = 1;

    // R1 reset values
    rd(AAl, r); check("R1 alarm", r, 0);
    rd(ACn, r); check("R1 count", r, 0);
    rd(ATr, r); check("R1 trim", r, 0);
    rd(ASt, r); check("R1 status", r, 0);
    check("R1 irq", {30'd0, irqTick, irqAlarm}, 0);

    // R2 readback with the prescaler halted (R7)
    for (int i = 0; i < 3; i++) begin
      v = $urandom;
      wr(AAl, v); rd(AAl, r); check("R2 alarm rb", r, v);
      wr(ACn, ~v); rd(ACn, r); check("R2 count rb", r, ~v);
    end
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, r); check("R2 unmapped", r, 0);
    rd(ATr, r);   check("R2 unmapped no write", r, 0);
    rd(ASt, r);   check("R2 unmapped no write stat", r, 0);

    // R3 enables readable; upper bits zero
    wr(ASt, 32'hFFFF_FFFC); rd(ASt, r); check("R3 enables", r, 32'hC);
    wr(ASt, 32'h0); rd(ASt, r); check("R3 enables off", r, 0);

    // R5 divider only, R8 first tick D+1 after count write
    wr(ATr, 32'd4);
    wr(ACn, 32'd100);
    rdAfter(4, ACn, r); check("R8 before first tick", r, 100);
    rdAfter(1, ACn, r); check("R5 first tick", r, expCount(100, 5, 4));
    rdAfter(5, ACn, r); check("R5 second tick", r, expCount(100, 10, 4));
    rd(ASt, r); check("R5 tick flag", r & 32'h2, 32'h2);

    // R10 tick interrupt gating
    wr(ASt, 32'h8); check("R10 irqTick on", {31'd0, irqTick}, 1);
    wr(ASt, 32'h0); check("R10 irqTick off", {31'd0, irqTick}, 0);

    // R7 halt, then R4 write-one-to-clear
    wr(ATr, 32'd0);
    wr(ACn, 32'd5);
    rdAfter(50, ACn, r); check("R7 halted", r, 5);
    wr(ASt, 32'h0); rd(ASt, r); check("R4 zero keeps", r & 32'h2, 32'h2);
    wr(ASt, 32'h2); rd(ASt, r); check("R4 one clears", r & 32'h2, 32'h0);

    // R6 trim: positive, negative, clamped negative
    trimCase(5, 3, "R6 trim plus");
    trimCase(5, -2, "R6 trim minus");
    trimCase(1, -5, "R6 trim clamp");

    // R8 restart mid-phase
    wr(ATr, 32'd9);
    wr(ACn, 32'd0);
    repeat (4) @(posedge clk); #1;
    wr(ACn, 32'd50);
    rdAfter(9, ACn, r);  check("R8 restart hold", r, 50);
    rdAfter(1, ACn, r);  check("R8 restart tick", r, expCount(50, 10, 9));

    // R9/R10 random alarm matches
    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      d = 1 + int'($urandom % 4);
      k = 1 + int'($urandom % 3);
      wr(ATr, 32'd0);
      wr(ACn, v);
      wr(AAl, v + 32'(k));
      wr(ASt, 32'h7);
      wr(ATr, 32'(d));
      wr(ACn, v);
      rdAfter(k * (d + 1), ASt, r); check("R9 not yet", r & 32'h1, 0);
      rdAfter(1, ASt, r);           check("R9 alarm set", r & 32'h1, 1);
      check("R10 irqAlarm", {31'd0, irqAlarm}, 1);
    end
    wr(ASt, 32'h1);
    check("R10 irqAlarm off", {31'd0, irqAlarm}, 0);

    // R9 match by alarm write while halted
    wr(ATr, 32'd0);
    wr(ACn, 32'd7);
    wr(ASt, 32'h3);
    wr(AAl, 32'd7);
    rdAfter(0, ASt, r); check("R9 alarm write pending", r & 32'h1, 0);
    rdAfter(1, ASt, r); check("R9 alarm write match", r & 32'h1, 1);

    // R11 clear colliding with a tick
    wr(ASt, 32'h2);
    wr(ATr, 32'd3);
    wr(ACn, 32'd0);
    repeat (3) @(posedge clk);
    wr(ASt, 32'h2);
    rd(ASt, r); check("R11 event wins", r & 32'h2, 32'h2);
    wr(ASt, 32'h2);
    rd(ASt, r); check("R4 clear after collision", r & 32'h2, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule